// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a memory-mapped countdown timer that produces an interrupt request tagged with a vector that software chooses. Software selects a clock ratio, fills in a timer entry that holds the vector, a mask bit and a mode bit, and then writes a starting count. The count is loaded when that register is written. It then steps down by one on every divided clock tick. When it expires, the block emits a one-cycle request together with the vector.

In one-shot mode the counter rests at zero after it expires. In periodic mode it reloads the starting count and runs again. Software can read the running count at any time. The block does not arbitrate or acknowledge interrupts; it only generates them.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset, irq_pulse and irq_vector are 0, and the registers read as follows: timer entry 0x0001_0000 (masked), starting count 0, running count 0, ratio field 0.
- R2: Byte offsets: 0x320 timer entry, 0x380 starting count, 0x390 running count, 0x3E0 ratio. Read data appears on bus_rdata one cycle after the read request. The timer entry keeps only bits 17, 16 and 7:0. The ratio register keeps only bits 3, 1 and 0. Unmapped offsets read 0.
- R3: A write of V to the starting count loads V into the running count at that clock edge and restarts the prescaler. Writing 0 leaves the count at 0, and no pulse follows.
- R4: The ratio code {bit3,bit1,bit0} = 000..110 divides by 2, 4, 8, 16, 32, 64, 128. Code 111 (register value 0xB) divides by 1.
- R5: With ratio D and starting count V, irq_pulse goes high exactly V·D clock edges after the edge that captured the write. It is high for one cycle when D·V > 1.
- R6: In one-shot mode (entry bit 17 = 0), the running count stays at 0 after expiry and no further pulse occurs until the starting count is written again.
- R7: In periodic mode (entry bit 17 = 1), the counter reloads the starting count on expiry and pulses every V·D edges.
- R8: Entry bit 16 = 1 suppresses irq_pulse, but counting and reload continue. The first pulse after unmasking falls on the next expiry.
- R9: During a pulse, irq_vector equals entry bits 7:0. At all other times it is 0.
- R10: Writes to the running-count offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector qualified by irq_pulse |

## Verification
A corrupted prescaler or counter state appears first as a pulse that arrives early or late. The gap between the write edge and the pulse is measured exactly, so an error of a single cycle is caught at the first expiry. A counter that fails to rest or reload shows up within one period as an extra or missing pulse, or as a nonzero running count read back after a one-shot run. A wrong mask or vector register is caught at the first pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [11:0] OFS_ENTRY = 12'h320;
  localparam logic [11:0] OFS_START = 12'h380;
  localparam logic [11:0] OFS_RUN   = 12'h390;
  localparam logic [11:0] OFS_RATIO = 12'h3E0;
  localparam int ENT_MASK_BIT = 16;
  localparam int ENT_PER_BIT  = 17;

  typedef struct packed {
    logic       periodic;
    logic       masked;
    logic [7:0] vector;
  } entry_t;

  function automatic logic [2:0] ratio_code(input logic [3:0] r);
    return {r[3], r[1], r[0]};
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] sel_mask;

  always_comb begin
    sel_mask = '0;
    for (int b = 0; b < PRE_W; b++)
      if (b <= int'(code)) sel_mask[b] = 1'b1;
  end

  always_comb begin
    if (code == 3'b111) tick = 1'b1;
    else                tick = ((pcnt & sel_mask) == sel_mask);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  input  logic          periodic,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] count,
  output logic          expire
);
  logic at_one;
  assign at_one = (count == CW'(1));
  assign expire = tick && at_one && !load;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (load) count <= load_val;
    else if (tick && count != '0) begin
      if (at_one) count <= periodic ? reload_val : '0;
      else        count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse,
  output logic [7:0]        irq_vector
);
  localparam int PRE_W = 7;

  entry_t             entry_q;
  logic [COUNT_W-1:0] start_q;
  logic [3:0]         ratio_q;
  logic [COUNT_W-1:0] run_count;
  logic               wr_start, tick, expire;
  logic [DATA_W-1:0]  rd_word;

  assign wr_start = bus_wr && (bus_addr == ADDR_W'(OFS_START));

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q <= '{periodic: 1'b0, masked: 1'b1, vector: 8'h00};
      start_q <= '0;
      ratio_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(OFS_ENTRY)) begin
        entry_q.periodic <= bus_wdata[ENT_PER_BIT];
        entry_q.masked   <= bus_wdata[ENT_MASK_BIT];
        entry_q.vector   <= bus_wdata[7:0];
      end
      if (wr_start) start_q <= bus_wdata[COUNT_W-1:0];
      if (bus_addr == ADDR_W'(OFS_RATIO))
        ratio_q <= {bus_wdata[3], 1'b0, bus_wdata[1:0]};
    end
  end

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .restart(wr_start),
    .code(ratio_code(ratio_q)), .tick(tick)
  );

  tmr_down_counter #(.CW(COUNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(wr_start), .load_val(bus_wdata[COUNT_W-1:0]),
    .tick(tick), .periodic(entry_q.periodic), .reload_val(start_q),
    .count(run_count), .expire(expire)
  );

  always_comb begin
    rd_word = '0;
    if (bus_addr == ADDR_W'(OFS_ENTRY)) begin
      rd_word[ENT_PER_BIT]  = entry_q.periodic;
      rd_word[ENT_MASK_BIT] = entry_q.masked;
      rd_word[7:0]          = entry_q.vector;
    end else if (bus_addr == ADDR_W'(OFS_START)) rd_word = DATA_W'(start_q);
    else if (bus_addr == ADDR_W'(OFS_RUN))       rd_word = DATA_W'(run_count);
    else if (bus_addr == ADDR_W'(OFS_RATIO))     rd_word = DATA_W'(ratio_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      irq_pulse  <= expire && !entry_q.masked;
      irq_vector <= (expire && !entry_q.masked) ? entry_q.vector : 8'h00;
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_start,
  input logic [CW-1:0] wdata_cnt,
  input logic [CW-1:0] count,
  input logic [CW-1:0] start_val,
  input logic          masked,
  input logic [7:0]    vector,
  input logic          irq,
  input logic [7:0]    irq_vec
);
  AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> count == $past(wdata_cnt)); // R3

  AST_REST_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !wr_start) |=> count == '0); // R6

  AST_STEP_OR_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (count != '0 && !wr_start) |=> (count == $past(count)) ||
      (count == $past(count) - 1'b1) ||
      ($past(count) == CW'(1) && count == $past(start_val))); // R7

  AST_PULSE_AFTER_ONE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(count) == CW'(1)); // R5

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    irq |-> !$past(masked)); // R8

  AST_VECTOR_QUAL: assert property (@(posedge clk) disable iff (rst)
    irq ? (irq_vec == $past(vector)) : (irq_vec == 8'h00)); // R9
endmodule

bind irq_countdown_timer tmr_checker #(.CW(COUNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_start(wr_start),
  .wdata_cnt(bus_wdata[COUNT_W-1:0]), .count(run_count), .start_val(start_q),
  .masked(entry_q.masked), .vector(entry_q.vector),
  .irq(irq_pulse), .irq_vec(irq_vector)
);

// File: tb/irq_countdown_timer_tb.sv
module irq_countdown_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [3:0]  ratio;
    logic [15:0] cnt;
    logic [15:0] edges;
  } vec_t;

  // ratio register value, starting count, expected edges to pulse (R4, R5)
  localparam vec_t TBL [9] = '{
    '{4'hB, 16'd5, 16'd5},   '{4'h0, 16'd3, 16'd6},
    '{4'h1, 16'd2, 16'd8},   '{4'h2, 16'd2, 16'd16},
    '{4'h3, 16'd1, 16'd16},  '{4'h8, 16'd1, 16'd32},
    '{4'h9, 16'd1, 16'd64},  '{4'hA, 16'd1, 16'd128},
    '{4'hB, 16'd1, 16'd1}
  };

  logic        clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pulse;
  logic [7:0]  irq_vector;
  int          n_run = 0, n_fail = 0, cycles = 0;
  logic        done = 0;

  irq_countdown_timer u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    while (!irq_pulse && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic count_pulses(input int len, output int p);
    p = 0;
    for (int k = 0; k < len; k++) begin @(negedge clk); if (irq_pulse) p++; end
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > WATCHDOG && !done) begin
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    int n, p;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(irq_pulse == 0 && irq_vector == 0, "R1 irq", irq_pulse, 0);
    rd(12'h320, d); check(d == 32'h0001_0000, "R1 entry", d, 32'h0001_0000);
    rd(12'h390, d); check(d == 0, "R1 running", d, 0);
    rd(12'h380, d); check(d == 0, "R1 start", d, 0);
    rd(12'h3E0, d); check(d == 0, "R1 ratio", d, 0);
    // R2 field masking and unmapped
    wr(12'h320, 32'hFFFF_FFFF); rd(12'h320, d);
    check(d == 32'h0003_00FF, "R2 entry bits", d, 32'h0003_00FF);
    wr(12'h3E0, 32'hFFFF_FFFF); rd(12'h3E0, d);
    check(d == 32'h0000_000B, "R2 ratio bits", d, 32'hB);
    rd(12'h330, d); check(d == 0, "R2 unmapped", d, 0);
    // R10 running count not writable
    wr(12'h390, 32'd77); rd(12'h390, d); check(d == 0, "R10 run write", d, 0);

    // R4 R5 R6 R9 table walk, one-shot unmasked
    for (int i = 0; i < 9; i++) begin
      wr(12'h3E0, {28'd0, TBL[i].ratio});
      wr(12'h320, 32'h40 + i);
      wr(12'h380, {16'd0, TBL[i].cnt});
      wait_pulse(n);
      check(n == int'(TBL[i].edges), "R4/R5 pulse delay", n, TBL[i].edges);
      check(irq_vector == 8'(8'h40 + i), "R9 vector", irq_vector, 8'h40 + i);
      @(negedge clk);
      if (TBL[i].edges > 1)
        check(irq_pulse == 0 && irq_vector == 0, "R5 one cycle", irq_pulse, 0);
      count_pulses(2 * int'(TBL[i].edges) + 8, p);
      check(p == 0, "R6 no repeat", p, 0);
      rd(12'h390, d); check(d == 0, "R6 rests at zero", d, 0);
    end

    // R3 load value visible, then write 0 stops
    wr(12'h3E0, 32'h0); wr(12'h320, 32'h0002_0011);
    wr(12'h380, 32'd100); rd(12'h390, d);
    check(d == 100, "R3 load", d, 100);
    wr(12'h380, 32'd0); rd(12'h390, d); check(d == 0, "R3 zero stops", d, 0);
    count_pulses(40, p); check(p == 0, "R3 zero no pulse", p, 0);

    // R7 periodic, ratio 2, count 3 -> every 6 edges
    wr(12'h380, 32'd3);
    wait_pulse(n); check(n == 6, "R7 first period", n, 6);
    check(irq_vector == 8'h11, "R9 periodic vector", irq_vector, 8'h11);
    @(negedge clk); n = 1;
    while (!irq_pulse && n < 100) begin @(negedge clk); n++; end
    check(n == 6, "R7 second period", n, 6);
    rd(12'h390, d); check(d >= 1 && d <= 3, "R7 reloaded", d, 3);

    // R8 mask: count continues, no pulse
    wr(12'h3E0, 32'hB); wr(12'h320, 32'h0003_0022); wr(12'h380, 32'd4);
    count_pulses(30, p); check(p == 0, "R8 masked", p, 0);
    rd(12'h390, d); check(d >= 1 && d <= 4, "R8 still counting", d, 4);
    wr(12'h320, 32'h0002_0022);
    wait_pulse(n); check(n <= 4, "R8 pulse after unmask", n, 4);
    check(irq_vector == 8'h22, "R9 vector after unmask", irq_vector, 8'h22);
    wr(12'h380, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule